// File: doc/BRIEF.md
# Four-Slot Breakpoint and Debug Event Unit

This unit watches a processor core's instruction fetches, memory accesses and I/O accesses and compares each one against four programmable address slots. It also collects the core's other debug triggers: the trap flag at instruction retirement, a switch into a task whose trap bit is set, the one-byte software breakpoint opcode, the two-byte software interrupt-1 opcode (CD 01), and any write to its own registers while write protection is armed. Each cycle's triggers are merged into one event. Depending on a routing bit, that event is either marked for the ordinary debug exception (vector 1) or diverted to an external debug-mode controller.

An execution hit is flagged in the same cycle as the fetch on `fetch_hold`, so the core can stop before the matched instruction runs. Software programs the slots and the control word through a plain write port and a combinational read port. It reads which triggers fired from a sticky status register, which it clears by writing ones.

The event output is a valid/ready stream:
- `evt_valid` rises one clock edge after the triggering cycle.
- `evt_src` and `evt_divert` stay constant while `evt_valid` is high and `evt_ready` is low.
- A new event may be loaded on the same edge that accepts the current one.
- Triggers that arrive while an event is stalled are recorded only in status; they raise no second event.

Top module: `dbg_brk_unit`

## Requirements
- R1: After reset, every register (slot addresses at 0-3, status at 4, control at 5) reads zero. Addresses 6 and 7 always read zero. `evt_valid` and `fetch_hold` are low.
- R2: A write to address 0-3 loads that slot's compare address, and a write to address 5 loads the control word. Both read back unchanged, except that control bits 8-11, 14 and 15 always read zero.
- R3: The control word has these fields. Bits 3:0 are the slot enables. Bits 7:4 select I/O space (1) or memory space (0) per slot. For slot i, bits [16+4i +: 2] hold the kind: 00 execute, 01 write, 10 read, 11 read-or-write. Bits [18+4i +: 2] hold the length: 00 = 1 byte, 01 = 2 bytes, 10 or 11 = 4 bytes. Bit 12 is the routing bit and bit 13 the protect bit.
- R4: A fetch whose address matches an enabled execute slot in memory space drives `fetch_hold` high in the same cycle. On the next edge it raises an event whose `evt_src` bit i (slot i) is set.
- R5: The length field ignores address bit 0 (2 bytes) or bits 1:0 (4 bytes) of both the access address and the slot address when comparing. A 1-byte slot needs an exact match.
- R6: Data slots match as follows.
  - A memory write slot matches memory writes, a memory read slot matches memory reads, and a read-or-write slot matches both.
  - An I/O slot matches only I/O accesses: write kind matches I/O writes, read kind matches I/O reads, and kinds 00 and 11 match either.
  - Fetches match only memory execute slots.
  - A memory execute slot ignores data accesses.
- R7: A disabled slot never asserts `fetch_hold`, never raises an event and never sets status.
- R8: Status and `evt_src` bits are:
  - 4: protected write.
  - 5: trap flag at retirement.
  - 6: task switch with the trap bit set.
  - 7: the software breakpoint opcode (parameter, default F1) as the first opcode byte.
  - 8: opcode bytes CD 01.

  Triggers in the same cycle form one event carrying all their bits.
- R9: While the protect bit is 1, a register write changes no register. Instead it sets status bit 4, raises an event, and clears the protect bit.
- R10: `evt_divert` equals the routing bit as it stood in the triggering cycle (1 = debug mode, 0 = vector 1).
- R11: Status bits stay set until a write of 1 to that bit at address 4. A trigger in the same cycle as a clear of its bit leaves the bit set.
- R12: While `evt_valid` is high and `evt_ready` is low, `evt_valid`, `evt_src` and `evt_divert` hold. Triggers during that time update status only. `evt_valid` drops after an accepting edge that carries no new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_io | input | 1 | Access targets I/O space |
| acc_wr | input | 1 | Data access is a write |
| acc_addr | input | ADDR_W | Access address |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_tf | input | 1 | Trap flag at that retirement |
| task_sw_valid | input | 1 | A task switch completes this cycle |
| task_tbit | input | 1 | Trap bit of the entered task |
| op_valid | input | 1 | Opcode bytes of a decoded instruction are valid |
| op_b0 | input | 8 | First opcode byte |
| op_b1 | input | 8 | Second opcode byte |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| fetch_hold | output | 1 | Execution slot hit on the current fetch |
| evt_valid | output | 1 | Debug event pending |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_divert | output | 1 | 1: send to debug mode, 0: raise vector 1 |
| evt_src | output | 9 | Sources merged into this event |

## Verification
On every cycle, the assertions check the following:
- A stalled event keeps its payload.
- Status bits never fall without a register write, and a trigger always lands in status.
- A protected write leaves the slot addresses unchanged and drops the protect bit.
- A disabled slot never reports a hit.
- The routing of a fresh event follows the routing bit of the prior cycle.

Only the bench's scenarios can show the rest:
- the address arithmetic of the length masks;
- the full kind-by-space-by-access matrix;
- the opcode decoding;
- read-back of the register map;
- the ordering of clear against set.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int N_SLOT   = 4;
  localparam int REG_W    = 32;
  localparam int STAT_W   = N_SLOT + 5;
  localparam int ST_PROT  = N_SLOT;
  localparam int ST_STEP  = N_SLOT + 1;
  localparam int ST_TASK  = N_SLOT + 2;
  localparam int ST_SWBP  = N_SLOT + 3;
  localparam int ST_INT1  = N_SLOT + 4;
  localparam int CB_IO0   = 4;
  localparam int CB_ROUTE = 12;
  localparam int CB_PROT  = 13;
  localparam int CB_SLOT0 = 16;
  localparam logic [2:0] RA_STAT = 3'd4;
  localparam logic [2:0] RA_CTRL = 3'd5;

  typedef enum logic [1:0] {
    K_EXEC = 2'b00,
    K_WR   = 2'b01,
    K_RD   = 2'b10,
    K_RW   = 2'b11
  } kind_e;

  typedef struct packed {
    logic       en;
    logic       io;
    kind_e      kind;
    logic [1:0] len;
  } slot_cfg_t;

  typedef struct packed {
    logic valid;
    logic fetch;
    logic io;
    logic wr;
  } acc_t;

  function automatic slot_cfg_t cfg_of(input logic [REG_W-1:0] c, input int i);
    slot_cfg_t r;
    r.en   = c[i];
    r.io   = c[CB_IO0 + i];
    r.kind = kind_e'(c[CB_SLOT0 + 4*i +: 2]);
    r.len  = c[CB_SLOT0 + 4*i + 2 +: 2];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      m[i] = 1'b1;
      m[CB_IO0 + i] = 1'b1;
      m[CB_SLOT0 + 4*i +: 4] = 4'hF;
    end
    m[CB_ROUTE] = 1'b1;
    m[CB_PROT]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dbg_slot_cmp.sv
module dbg_slot_cmp
  import dbg_brk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  slot_cfg_t          cfg,
  input  logic [ADDR_W-1:0]  base,
  input  acc_t               acc,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic               exec_hit
);
  logic [ADDR_W-1:0] low_mask;
  logic              addr_eq;
  logic              kind_ok;

  always_comb begin
    low_mask = '0;
    unique case (cfg.len)
      2'b00:   low_mask[1:0] = 2'b00;
      2'b01:   low_mask[1:0] = 2'b01;
      default: low_mask[1:0] = 2'b11;
    endcase
  end

  assign addr_eq = (((addr ^ base) & ~low_mask) == '0);

  always_comb begin
    kind_ok = 1'b0;
    if (!acc.valid) begin
      kind_ok = 1'b0;
    end else if (acc.fetch) begin
      kind_ok = !cfg.io && (cfg.kind == K_EXEC);
    end else if (acc.io != cfg.io) begin
      kind_ok = 1'b0;
    end else if (cfg.io) begin
      unique case (cfg.kind)
        K_WR:    kind_ok = acc.wr;
        K_RD:    kind_ok = !acc.wr;
        default: kind_ok = 1'b1;
      endcase
    end else begin
      unique case (cfg.kind)
        K_EXEC:  kind_ok = 1'b0;
        K_WR:    kind_ok = acc.wr;
        K_RD:    kind_ok = !acc.wr;
        default: kind_ok = 1'b1;
      endcase
    end
  end

  assign hit      = cfg.en && kind_ok && addr_eq;
  assign exec_hit = hit && acc.fetch;
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbg_brk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_we,
  input  logic [2:0]                       reg_waddr,
  input  logic [REG_W-1:0]                 reg_wdata,
  input  logic [2:0]                       reg_raddr,
  output logic [REG_W-1:0]                 reg_rdata,
  input  logic [STAT_W-1:0]                src_all,
  output logic                             prot_hit,
  output logic [REG_W-1:0]                 ctrl,
  output logic [N_SLOT-1:0][ADDR_W-1:0]    base,
  output logic [STAT_W-1:0]                status
);
  localparam logic [REG_W-1:0] CMASK = ctrl_mask();

  logic [N_SLOT-1:0][ADDR_W-1:0] base_q;
  logic [REG_W-1:0]              ctrl_q;
  logic [STAT_W-1:0]             status_q;
  logic                          wr_ok;
  logic [STAT_W-1:0]             clr;

  assign wr_ok    = reg_we && !ctrl_q[CB_PROT];
  assign prot_hit = reg_we && ctrl_q[CB_PROT];
  assign clr      = (wr_ok && reg_waddr == RA_STAT) ? reg_wdata[STAT_W-1:0] : '0;

  for (genvar i = 0; i < N_SLOT; i++) begin : g_base
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i] <= '0;
      end else if (wr_ok && reg_waddr == 3'(i)) begin
        base_q[i] <= reg_wdata[ADDR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ok && reg_waddr == RA_CTRL) begin
      ctrl_q <= reg_wdata & CMASK;
    end else if (prot_hit) begin
      ctrl_q[CB_PROT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr) | src_all;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr[2] == 1'b0) begin
      reg_rdata[ADDR_W-1:0] = base_q[reg_raddr[1:0]];
    end else if (reg_raddr == RA_STAT) begin
      reg_rdata[STAT_W-1:0] = status_q;
    end else if (reg_raddr == RA_CTRL) begin
      reg_rdata = ctrl_q;
    end
  end

  assign ctrl   = ctrl_q;
  assign base   = base_q;
  assign status = status_q;

  // R9
  prot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit |=> $stable(base_q));
  // R9
  prot_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit |=> !ctrl_q[CB_PROT]);
  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_all) |=> ((status_q & $past(src_all)) == $past(src_all)));
endmodule

// File: rtl/dbg_evt_port.sv
module dbg_evt_port
  import dbg_brk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] src_all,
  input  logic              route,
  input  logic              evt_ready,
  output logic              evt_valid,
  output logic [STAT_W-1:0] evt_src,
  output logic              evt_divert
);
  logic load;

  assign load = (|src_all) && (!evt_valid || evt_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid  <= 1'b0;
      evt_src    <= '0;
      evt_divert <= 1'b0;
    end else if (load) begin
      evt_valid  <= 1'b1;
      evt_src    <= src_all;
      evt_divert <= route;
    end else if (evt_ready) begin
      evt_valid  <= 1'b0;
    end
  end

  // R12
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_src) && $stable(evt_divert));
  // R12
  evt_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_src != '0));
  // R10
  route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> (evt_divert == $past(route)));
endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
  import dbg_brk_pkg::*;
#(
  parameter int         ADDR_W  = 32,
  parameter logic [7:0] SWBP_OP = 8'hF1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_fetch,
  input  logic                acc_io,
  input  logic                acc_wr,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic                ret_valid,
  input  logic                ret_tf,
  input  logic                task_sw_valid,
  input  logic                task_tbit,
  input  logic                op_valid,
  input  logic [7:0]          op_b0,
  input  logic [7:0]          op_b1,
  input  logic                reg_we,
  input  logic [2:0]          reg_waddr,
  input  logic [31:0]         reg_wdata,
  input  logic [2:0]          reg_raddr,
  output logic [31:0]         reg_rdata,
  output logic                fetch_hold,
  output logic                evt_valid,
  input  logic                evt_ready,
  output logic                evt_divert,
  output logic [STAT_W-1:0]   evt_src
);
  localparam logic [7:0] INT_OP  = 8'hCD;
  localparam logic [7:0] INT_VEC = 8'h01;

  logic [REG_W-1:0]              ctrl;
  logic [N_SLOT-1:0][ADDR_W-1:0] base;
  logic [STAT_W-1:0]             status;
  logic [STAT_W-1:0]             src_all;
  logic [N_SLOT-1:0]             hit;
  logic [N_SLOT-1:0]             exec_hit;
  logic                          prot_hit;
  slot_cfg_t [N_SLOT-1:0]        cfg;
  acc_t                          acc;

  assign acc = '{valid: acc_valid, fetch: acc_fetch, io: acc_io, wr: acc_wr};

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    assign cfg[i] = cfg_of(ctrl, i);
    dbg_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .cfg      (cfg[i]),
      .base     (base[i]),
      .acc      (acc),
      .addr     (acc_addr),
      .hit      (hit[i]),
      .exec_hit (exec_hit[i])
    );
    // R7
    slot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg[i].en |-> !hit[i]);
  end

  always_comb begin
    src_all = '0;
    src_all[N_SLOT-1:0] = hit;
    src_all[ST_PROT]    = prot_hit;
    src_all[ST_STEP]    = ret_valid && ret_tf;
    src_all[ST_TASK]    = task_sw_valid && task_tbit;
    src_all[ST_SWBP]    = op_valid && (op_b0 == SWBP_OP);
    src_all[ST_INT1]    = op_valid && (op_b0 == INT_OP) && (op_b1 == INT_VEC);
  end

  assign fetch_hold = |exec_hit;

  dbg_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata),
    .src_all   (src_all),
    .prot_hit  (prot_hit),
    .ctrl      (ctrl),
    .base      (base),
    .status    (status)
  );

  dbg_evt_port u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_all    (src_all),
    .route      (ctrl[CB_ROUTE]),
    .evt_ready  (evt_ready),
    .evt_valid  (evt_valid),
    .evt_src    (evt_src),
    .evt_divert (evt_divert)
  );

  // R4
  hold_logs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hold |=> (|status[N_SLOT-1:0]));
endmodule

// File: tb/dbg_brk_unit_test.sv
module dbg_brk_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int B_PROT = 4, B_STEP = 5, B_TASK = 6, B_SWBP = 7, B_INT1 = 8;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_fetch = 0, acc_io = 0, acc_wr = 0;
  logic [31:0] acc_addr = 0;
  logic ret_valid = 0, ret_tf = 0, task_sw_valid = 0, task_tbit = 0, op_valid = 0;
  logic [7:0] op_b0 = 0, op_b1 = 0;
  logic reg_we = 0;
  logic [2:0] reg_waddr = 0, reg_raddr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic fetch_hold, evt_valid, evt_divert, evt_ready = 1;
  logic [8:0] evt_src;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_brk_unit uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fetch(acc_fetch),
    .acc_io(acc_io), .acc_wr(acc_wr), .acc_addr(acc_addr), .ret_valid(ret_valid),
    .ret_tf(ret_tf), .task_sw_valid(task_sw_valid), .task_tbit(task_tbit),
    .op_valid(op_valid), .op_b0(op_b0), .op_b1(op_b1), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
    .reg_rdata(reg_rdata), .fetch_hold(fetch_hold), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_divert(evt_divert), .evt_src(evt_src));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_waddr = a; reg_wdata = d;
    @(posedge clk); #1; reg_we = 0;
  endtask

  task automatic clr_stat(); wreg(3'd4, 32'h1FF); @(posedge clk); #1; endtask

  // one cycle of non-access sources
  task automatic src_cycle(input bit st, input bit tk, input bit ov, input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk);
    ret_valid = st; ret_tf = st; task_sw_valid = tk; task_tbit = tk;
    op_valid = ov; op_b0 = b0; op_b1 = b1;
    @(posedge clk); #1;
    ret_valid = 0; ret_tf = 0; task_sw_valid = 0; task_tbit = 0; op_valid = 0;
  endtask

  function automatic bit kind_exp(input bit cio, input int k, input int a);
    bit aio, wr;
    if (a == 0) return !cio && k == 0;
    aio = (a >= 3); wr = (a == 2 || a == 4);
    if (aio != cio) return 0;
    if (cio) return (k == 0 || k == 3) ? 1'b1 : (k == 1 ? wr : !wr);
    return (k == 0) ? 1'b0 : (k == 1 ? wr : (k == 2 ? !wr : 1'b1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), d); chk(d == 0, "R1 reg", d, 0); end
    chk(!evt_valid && !fetch_hold, "R1 outputs", {evt_valid, fetch_hold}, 0);

    // R2 / R3 map and reserved bits
    for (int a = 0; a < 4; a++) wreg(3'(a), 32'h1111_0000 * (a + 1) + 32'h55);
    wreg(3'd5, 32'hFFFF_DFFF);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d); chk(d == 32'h1111_0000 * (a + 1) + 32'h55, "R2 slot", d, 32'h1111_0000 * (a + 1) + 32'h55);
    end
    rd(3'd5, d); chk(d == 32'hFFFF_10FF, "R3 ctrl mask", d, 32'hFFFF_10FF);
    rd(3'd6, d); chk(d == 0, "R2 addr6", d, 0);
    rd(3'd7, d); chk(d == 0, "R2 addr7", d, 0);
    wreg(3'd5, 0);

    // R4 R5 sweep: slot x length x offset on fetches
    for (int s = 0; s < 4; s++)
      for (int ln = 0; ln < 4; ln++)
        for (int off = 0; off < 8; off++) begin
          logic [31:0] base, addr, m;
          bit e;
          base = 32'h4A00 + s * 16 + 2;
          addr = 32'h4A00 + s * 16 + off;
          m = (ln == 0) ? 0 : (ln == 1 ? 1 : 3);
          e = (((addr ^ base) & ~m) == 0);
          wreg(3'(s), base);
          wreg(3'd5, (32'h1 << s) | (32'(ln) << (18 + 4 * s)));
          @(negedge clk); acc_valid = 1; acc_fetch = 1; acc_addr = addr; #1;
          chk(fetch_hold == e, "R5 fetch_hold", fetch_hold, e);
          @(posedge clk); #1; acc_valid = 0; acc_fetch = 0;
          chk(evt_valid == e, "R4 evt_valid", evt_valid, e);
          if (e) chk(evt_src == 9'(1 << s), "R4 evt_src", evt_src, 1 << s);
          clr_stat();
        end

    // R6 kind x space x access matrix on slot 1
    wreg(3'd1, 32'h300);
    for (int cio = 0; cio < 2; cio++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 5; a++) begin
          bit e;
          e = kind_exp(cio[0], k, a);
          wreg(3'd5, 32'h2 | (32'(cio) << 5) | (32'(k) << 20));
          @(negedge clk);
          acc_valid = 1; acc_fetch = (a == 0); acc_io = (a >= 3); acc_wr = (a == 2 || a == 4);
          acc_addr = 32'h300;
          @(posedge clk); #1; acc_valid = 0; acc_fetch = 0; acc_io = 0; acc_wr = 0;
          chk(evt_valid == e && (!e || evt_src == 9'h2), "R6 kind match", {evt_valid, evt_src}, {e, 9'(e ? 2 : 0)});
          clr_stat();
        end
    // R6 I/O either-kind address miss
    wreg(3'd5, 32'h2 | 32'h20 | (32'h3 << 20));
    @(negedge clk); acc_valid = 1; acc_io = 1; acc_wr = 1; acc_addr = 32'h301;
    @(posedge clk); #1; acc_valid = 0; acc_io = 0; acc_wr = 0;
    chk(!evt_valid, "R6 io addr miss", evt_valid, 0);

    // R7 disabled slot
    wreg(3'd2, 32'h500);
    wreg(3'd5, 32'h0);
    @(negedge clk); acc_valid = 1; acc_fetch = 1; acc_addr = 32'h500; #1;
    chk(!fetch_hold, "R7 hold", fetch_hold, 0);
    @(posedge clk); #1; acc_valid = 0; acc_fetch = 0;
    chk(!evt_valid, "R7 evt", evt_valid, 0);
    rd(3'd4, d); chk(d == 0, "R7 status", d, 0);

    // R8 individual sources and non-matching opcodes
    src_cycle(1, 0, 0, 0, 0); chk(evt_src == 9'(1 << B_STEP), "R8 step", evt_src, 1 << B_STEP); clr_stat();
    src_cycle(0, 1, 0, 0, 0); chk(evt_src == 9'(1 << B_TASK), "R8 task", evt_src, 1 << B_TASK); clr_stat();
    src_cycle(0, 0, 1, 8'hF1, 8'h00); chk(evt_src == 9'(1 << B_SWBP), "R8 swbp", evt_src, 1 << B_SWBP); clr_stat();
    src_cycle(0, 0, 1, 8'hCD, 8'h01); chk(evt_src == 9'(1 << B_INT1), "R8 int1", evt_src, 1 << B_INT1); clr_stat();
    src_cycle(0, 0, 1, 8'hCD, 8'h02); chk(!evt_valid, "R8 int other", evt_valid, 0);
    src_cycle(0, 0, 0, 8'hF1, 8'h00); chk(!evt_valid, "R8 op invalid", evt_valid, 0);
    src_cycle(1, 1, 0, 0, 0);
    chk(evt_valid && evt_src == 9'h060, "R8 merged", evt_src, 9'h060); clr_stat();

    // R10 routing
    wreg(3'd5, 32'h1000);
    src_cycle(1, 0, 0, 0, 0); chk(evt_divert == 1, "R10 divert", evt_divert, 1); clr_stat();
    wreg(3'd5, 32'h0);
    src_cycle(1, 0, 0, 0, 0); chk(evt_divert == 0, "R10 vector1", evt_divert, 0); clr_stat();

    // R12 back-pressure
    evt_ready = 0;
    src_cycle(1, 0, 0, 0, 0);
    src_cycle(0, 1, 0, 0, 0);
    chk(evt_valid && evt_src == 9'(1 << B_STEP), "R12 held", evt_src, 1 << B_STEP);
    rd(3'd4, d); chk(d == 32'h060, "R12 status both", d, 32'h060);
    @(negedge clk); evt_ready = 1;
    @(posedge clk); #1;
    chk(!evt_valid, "R12 drop", evt_valid, 0);

    // R11 sticky, partial clear, set wins
    repeat (3) @(posedge clk); #1;
    rd(3'd4, d); chk(d == 32'h060, "R11 sticky", d, 32'h060);
    wreg(3'd4, 32'h020);
    rd(3'd4, d); chk(d == 32'h040, "R11 w1c", d, 32'h040);
    @(negedge clk); reg_we = 1; reg_waddr = 3'd4; reg_wdata = 32'h040; task_sw_valid = 1; task_tbit = 1;
    @(posedge clk); #1; reg_we = 0; task_sw_valid = 0; task_tbit = 0;
    rd(3'd4, d); chk(d == 32'h040, "R11 set wins", d, 32'h040);
    clr_stat();

    // R9 protected write
    wreg(3'd0, 32'h0000_1234);
    wreg(3'd5, 32'h2000);
    wreg(3'd0, 32'h0000_DEAD);
    chk(evt_valid && evt_src == 9'(1 << B_PROT), "R9 event", evt_src, 1 << B_PROT);
    rd(3'd0, d); chk(d == 32'h1234, "R9 slot kept", d, 32'h1234);
    rd(3'd4, d); chk(d == 32'(1 << B_PROT), "R9 status", d, 1 << B_PROT);
    rd(3'd5, d); chk(d == 0, "R9 protect cleared", d, 0);
    wreg(3'd0, 32'h0000_BEEF);
    rd(3'd0, d); chk(d == 32'hBEEF, "R9 write after", d, 32'hBEEF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule